// File: doc/BRIEF.md
# SCSI Initiator Command Sequencer

This block is the command engine inside a SCSI controller that runs as initiator. A host writes one command byte at a time. The block decodes the byte and then carries out the bus work on its own. That work covers selecting a target, pushing an optional message byte and the command bytes out of a 16-entry data FIFO, and collecting status and message bytes. It also covers a plain information transfer in whichever phase the target has set. Bit 7 of the command byte asks for a DMA-sized transfer.

Each selection command runs a short list of steps. Every step carries a step number and a set of interrupt bits. The list moves forward each time the target changes the bus phase to a phase other than bus free. The last step number reached stays readable, so the host can tell how far a command got. The host sees the result in a 4-bit interrupt status register that drives an IRQ line. A read pulse clears that register.

On the bus side, the block works with an abstract bus model. The model reports selection success or timeout, phase changes and the current phase. It also takes pushed bytes, supplies pulled bytes, and sees the SEL and ACK levels.

Top module: `scsi_init_seq`

## Requirements
- R1: After reset the sequencer is idle, status bits, IRQ and step number are zero, the FIFO is empty, and SEL, ACK and the pull request are low.
- R2: Command codes sit in bits 6:0 and bit 7 is the DMA flag. The codes are 0x10 transfer, 0x11 complete steps, 0x12 message accepted, 0x41 select, 0x42 select with attention and 0x44 enable selection. Any other code sets the rejected bit (bit 3). A command byte written while busy is ignored.
- R3: The FIFO holds 16 bytes in first-in first-out order. A host write to a full FIFO, and any host FIFO access while busy, is ignored. The level never exceeds 16.
- R4: Select (0x41) drives SEL until selection succeeds. At the next qualifying phase change it pushes every FIFO byte in order and reports step 3. At the following one it reports step 4 and sets service request (bit 1) and success (bit 0).
- R5: Select with attention (0x42) first pushes exactly one FIFO head byte as step 2. It then pushes the remaining bytes as step 3, then reports step 4 with bits 1 and 0.
- R6: A selection timeout drops SEL, reports step 0, sets disconnect (bit 2), raises IRQ and returns to idle.
- R7: A phase change to bus free (code 4), or any phase change while no selection list is waiting, has no effect.
- R8: Complete steps (0x11) is rejected unless the phase is STATUS (code 3). Otherwise it pulls one status byte and one message byte into the FIFO, asserts ACK and sets bit 1. Message accepted (0x12) releases ACK and sets bit 1.
- R9: A transfer when not initiator, or with the phase set to bus free, sets bit 3 and causes no bus activity.
- R10: A transfer in an output phase (0 data out, 2 command, 6 message out) pushes all FIFO bytes in order, leaves the FIFO empty and sets bit 1.
- R11: A transfer in an input phase (1 data in, 3 status, 7 message in) pulls bytes into the FIFO and then sets bit 1. With DMA in data in, the count is min(transfer count, 16 minus level), and zero means no pull. In every other input case exactly one byte is pulled.
- R12: A status read pulse clears all status bits and drops IRQ on the next cycle. The step number is cleared when a command starts and otherwise holds.
- R13: Enable selection (0x44) completes at once with no interrupt and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte, bit 7 = DMA |
| busy | output | 1 | Sequencer is running a command |
| fifo_we | input | 1 | Host FIFO write strobe |
| fifo_wdata | input | 8 | Host FIFO write byte |
| fifo_re | input | 1 | Host FIFO read strobe |
| fifo_rdata | output | 8 | FIFO read byte, valid the cycle after a read |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | FIFO occupancy |
| xfer_we | input | 1 | Transfer count load strobe |
| xfer_wdata | input | CNT_W | Transfer count value |
| isr_rd | input | 1 | Status read pulse, clears the status bits |
| int_status | output | 4 | Status bits: 0 success, 1 service request, 2 disconnect, 3 rejected |
| step_num | output | 3 | Last step number reached |
| irq | output | 1 | Interrupt request |
| initiator_mode | input | 1 | Controller currently acts as initiator |
| bus_phase | input | 3 | Current bus phase code |
| phase_chg | input | 1 | Pulse: the target changed the phase to bus_phase |
| sel_out | output | 1 | SEL driven during selection |
| sel_done | input | 1 | Pulse: selection succeeded |
| sel_timeout | input | 1 | Pulse: selection timed out |
| push_valid | output | 1 | A byte is pushed to the bus |
| push_data | output | 8 | Pushed byte |
| pull_req | output | 1 | Sequencer wants a byte from the bus |
| pull_valid | input | 1 | Bus delivers a byte |
| pull_data | input | 8 | Delivered byte |
| ack_out | output | 1 | ACK level after the message byte |

## Verification
The bench uses the default 16-entry FIFO and narrows the transfer counter to 6 bits. Every FIFO occupancy from 0 to 16 is paired with every transfer count from 0 to 20. This covers both sides of the min rule, including a zero count and a full FIFO. Output transfers are swept over all three output phases with 0 to 16 queued bytes. The selection lists are walked step by step, with bus-free and idle phase changes mixed in.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

  localparam int STEP_W = 3;
  localparam int ISR_W  = 4;

  // status bit positions
  localparam int ISR_SO  = 0;
  localparam int ISR_SR  = 1;
  localparam int ISR_DIS = 2;
  localparam int ISR_REJ = 3;

  // bus phase codes {msg, c/d, i/o}; 4 is used for bus free
  localparam logic [2:0] PH_DOUT = 3'd0;
  localparam logic [2:0] PH_DIN  = 3'd1;
  localparam logic [2:0] PH_CMD  = 3'd2;
  localparam logic [2:0] PH_STAT = 3'd3;
  localparam logic [2:0] PH_FREE = 3'd4;
  localparam logic [2:0] PH_MOUT = 3'd6;
  localparam logic [2:0] PH_MIN  = 3'd7;

  // command opcodes (bits 6:0 of the command byte)
  localparam logic [6:0] OP_XFER   = 7'h10;
  localparam logic [6:0] OP_FINISH = 7'h11;
  localparam logic [6:0] OP_MSGOK  = 7'h12;
  localparam logic [6:0] OP_SEL    = 7'h41;
  localparam logic [6:0] OP_SELATN = 7'h42;
  localparam logic [6:0] OP_ARM    = 7'h44;

  typedef enum logic [1:0] {ACT_SEL, ACT_MSG, ACT_CMD, ACT_FIN} act_e;

  typedef struct packed {
    act_e              act;
    logic [STEP_W-1:0] step;
    logic [ISR_W-1:0]  stat;
  } desc_t;

  typedef enum logic [2:0] {ST_IDLE, ST_SEL, ST_WAIT, ST_PUSH, ST_PULL} seq_state_e;

  // step list of the two selection commands
  function automatic desc_t desc_lookup(input logic atn, input logic [1:0] idx);
    desc_t d;
    if (idx == 2'd0) begin
      d.act  = ACT_SEL;
      d.step = STEP_W'(0);
      d.stat = ISR_W'(1 << ISR_DIS);
    end else if (atn && idx == 2'd1) begin
      d.act  = ACT_MSG;
      d.step = STEP_W'(2);
      d.stat = ISR_W'((1 << ISR_SR) | (1 << ISR_SO));
    end else if (idx == (atn ? 2'd2 : 2'd1)) begin
      d.act  = ACT_CMD;
      d.step = STEP_W'(3);
      d.stat = ISR_W'((1 << ISR_SR) | (1 << ISR_SO));
    end else begin
      d.act  = ACT_FIN;
      d.step = STEP_W'(4);
      d.stat = ISR_W'((1 << ISR_SR) | (1 << ISR_SO));
    end
    return d;
  endfunction

endpackage

// File: rtl/scsi_seq_fifo.sv
module scsi_seq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr_en && (level != FULL);
  assign rd_ok = rd_en && (level != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_ok) begin
      rd_data <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    level <= FULL) else $error("fifo level above depth");

  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (level == FULL && wr_en && !rd_en) |=> level == FULL)
    else $error("write to full fifo changed level");

endmodule

// File: rtl/scsi_seq_irq.sv
module scsi_seq_irq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits,
  input  logic         clr,
  output logic [W-1:0] isr,
  output logic         irq
);

  logic [W-1:0] isr_n;

  // a set arriving with a clear survives
  assign isr_n = (clr ? '0 : isr) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr <= '0;
      irq <= 1'b0;
    end else begin
      isr <= isr_n;
      irq <= |isr_n;
    end
  end

  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (clr && set_bits == '0) |=> !irq) else $error("irq held after status read");

endmodule

// File: rtl/scsi_seq_ctrl.sv
module scsi_seq_ctrl import scsi_seq_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int MW   = (CNT_W > LW) ? CNT_W : LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_data,
  input  logic [CNT_W-1:0]  xfer_cnt,
  input  logic [LW-1:0]     fifo_level,
  input  logic              initiator_mode,
  input  logic [2:0]        bus_phase,
  input  logic              phase_chg,
  input  logic              sel_done,
  input  logic              sel_timeout,
  input  logic              pull_valid,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic [ISR_W-1:0]  isr_set,
  output logic              fifo_pop,
  output logic              fifo_fill,
  output logic              sel_out,
  output logic              push_valid,
  output logic              pull_req,
  output logic              ack_out
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] ONE  = LW'(1);

  seq_state_e        state, state_n;
  logic [1:0]        idx, idx_n;
  logic [LW-1:0]     left, left_n;
  logic              atn, atn_n;
  logic              fin_cmd, fin_n;
  logic              stage, stage_n;
  logic              then_wait, then_wait_n;
  logic [STEP_W-1:0] step_n;
  logic              ack_n;
  desc_t             d_cur, d_next;

  logic [MW-1:0]     free_ext, cnt_ext;
  logic [LW-1:0]     dma_req, in_req;
  logic              out_phase, in_phase;

  assign d_cur    = desc_lookup(atn, idx);
  assign d_next   = desc_lookup(atn, idx + 2'd1);

  assign free_ext = MW'(FULL - fifo_level);
  assign cnt_ext  = MW'(xfer_cnt);
  assign dma_req  = (cnt_ext < free_ext) ? cnt_ext[LW-1:0] : free_ext[LW-1:0];
  assign in_req   = (cmd_data[7] && bus_phase == PH_DIN) ? dma_req : ONE;

  assign out_phase = (bus_phase == PH_DOUT) || (bus_phase == PH_CMD) || (bus_phase == PH_MOUT);
  assign in_phase  = (bus_phase == PH_DIN) || (bus_phase == PH_STAT) || (bus_phase == PH_MIN);

  always_comb begin
    state_n     = state;
    idx_n       = idx;
    left_n      = left;
    atn_n       = atn;
    fin_n       = fin_cmd;
    stage_n     = stage;
    then_wait_n = then_wait;
    step_n      = step;
    ack_n       = ack_out;
    isr_set     = '0;
    fifo_pop    = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (cmd_we) begin
          step_n = '0;
          case (cmd_data[6:0])
            OP_SEL, OP_SELATN: begin
              atn_n   = (cmd_data[6:0] == OP_SELATN);
              idx_n   = 2'd0;
              state_n = ST_SEL;
            end
            OP_FINISH: begin
              if (bus_phase == PH_STAT) begin
                fin_n   = 1'b1;
                stage_n = 1'b0;
                left_n  = ONE;
                state_n = ST_PULL;
              end else begin
                isr_set[ISR_REJ] = 1'b1;
              end
            end
            OP_MSGOK: begin
              ack_n           = 1'b0;
              isr_set[ISR_SR] = 1'b1;
            end
            OP_ARM: begin
              state_n = ST_IDLE;
            end
            OP_XFER: begin
              if (!initiator_mode || !(out_phase || in_phase)) begin
                isr_set[ISR_REJ] = 1'b1;
              end else if (out_phase) begin
                if (fifo_level == '0) begin
                  isr_set[ISR_SR] = 1'b1;
                end else begin
                  left_n      = fifo_level;
                  then_wait_n = 1'b0;
                  state_n     = ST_PUSH;
                end
              end else begin
                if (in_req == '0) begin
                  isr_set[ISR_SR] = 1'b1;
                end else begin
                  fin_n   = 1'b0;
                  left_n  = in_req;
                  state_n = ST_PULL;
                end
              end
            end
            default: isr_set[ISR_REJ] = 1'b1;
          endcase
        end
      end

      ST_SEL: begin
        if (sel_timeout) begin
          step_n  = d_cur.step;
          isr_set = d_cur.stat;
          state_n = ST_IDLE;
        end else if (sel_done) begin
          state_n = ST_WAIT;
        end
      end

      ST_WAIT: begin
        if (phase_chg && bus_phase != PH_FREE) begin
          idx_n  = idx + 2'd1;
          step_n = d_next.step;
          case (d_next.act)
            ACT_MSG: begin
              if (fifo_level != '0) begin
                left_n      = ONE;
                then_wait_n = 1'b1;
                state_n     = ST_PUSH;
              end
            end
            ACT_CMD: begin
              if (fifo_level != '0) begin
                left_n      = fifo_level;
                then_wait_n = 1'b1;
                state_n     = ST_PUSH;
              end
            end
            ACT_FIN: begin
              isr_set = d_next.stat;
              state_n = ST_IDLE;
            end
            default: state_n = ST_WAIT;
          endcase
        end
      end

      ST_PUSH: begin
        fifo_pop = 1'b1;
        left_n   = left - ONE;
        if (left == ONE) begin
          if (then_wait) begin
            state_n = ST_WAIT;
          end else begin
            isr_set[ISR_SR] = 1'b1;
            state_n         = ST_IDLE;
          end
        end
      end

      ST_PULL: begin
        if (pull_valid) begin
          left_n = left - ONE;
          if (left == ONE) begin
            if (fin_cmd && !stage) begin
              stage_n = 1'b1;
              left_n  = ONE;
            end else begin
              if (fin_cmd) ack_n = 1'b1;
              isr_set[ISR_SR] = 1'b1;
              state_n         = ST_IDLE;
            end
          end
        end
      end

      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      left       <= '0;
      atn        <= 1'b0;
      fin_cmd    <= 1'b0;
      stage      <= 1'b0;
      then_wait  <= 1'b0;
      step       <= '0;
      ack_out    <= 1'b0;
      push_valid <= 1'b0;
    end else begin
      state      <= state_n;
      idx        <= idx_n;
      left       <= left_n;
      atn        <= atn_n;
      fin_cmd    <= fin_n;
      stage      <= stage_n;
      then_wait  <= then_wait_n;
      step       <= step_n;
      ack_out    <= ack_n;
      push_valid <= fifo_pop;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign sel_out   = (state == ST_SEL);
  assign pull_req  = (state == ST_PULL);
  assign fifo_fill = (state == ST_PULL) && pull_valid;

  assert_push_after_pop_R10: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> $past(state == ST_PUSH)) else $error("push without pop");

  assert_step_legal_R4: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd0 || step == 3'd2 || step == 3'd3 || step == 3'd4))
    else $error("illegal step number");

endmodule

// File: rtl/scsi_init_seq.sv
module scsi_init_seq import scsi_seq_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cmd_we,
  input  logic [7:0]                         cmd_data,
  output logic                               busy,
  input  logic                               fifo_we,
  input  logic [7:0]                         fifo_wdata,
  input  logic                               fifo_re,
  output logic [7:0]                         fifo_rdata,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]    fifo_level,
  input  logic                               xfer_we,
  input  logic [CNT_W-1:0]                   xfer_wdata,
  input  logic                               isr_rd,
  output logic [3:0]                         int_status,
  output logic [2:0]                         step_num,
  output logic                               irq,
  input  logic                               initiator_mode,
  input  logic [2:0]                         bus_phase,
  input  logic                               phase_chg,
  output logic                               sel_out,
  input  logic                               sel_done,
  input  logic                               sel_timeout,
  output logic                               push_valid,
  output logic [7:0]                         push_data,
  output logic                               pull_req,
  input  logic                               pull_valid,
  input  logic [7:0]                         pull_data,
  output logic                               ack_out
);

  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic [CNT_W-1:0] xfer_q;
  logic [ISR_W-1:0] isr_set;
  logic             seq_pop, seq_fill;
  logic             f_wr, f_rd;
  logic [7:0]       f_wdata, f_rdata;
  logic [LW-1:0]    f_level;

  always_ff @(posedge clk) begin
    if (rst)          xfer_q <= '0;
    else if (xfer_we) xfer_q <= xfer_wdata;
  end

  // the sequencer owns the FIFO while busy; host access is dropped then
  assign f_wr    = busy ? seq_fill  : fifo_we;
  assign f_wdata = busy ? pull_data : fifo_wdata;
  assign f_rd    = busy ? seq_pop   : fifo_re;

  scsi_seq_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) i_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (f_wr),
    .wr_data (f_wdata),
    .rd_en   (f_rd),
    .rd_data (f_rdata),
    .level   (f_level)
  );

  scsi_seq_ctrl #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_ctrl (
    .clk            (clk),
    .rst            (rst),
    .cmd_we         (cmd_we),
    .cmd_data       (cmd_data),
    .xfer_cnt       (xfer_q),
    .fifo_level     (f_level),
    .initiator_mode (initiator_mode),
    .bus_phase      (bus_phase),
    .phase_chg      (phase_chg),
    .sel_done       (sel_done),
    .sel_timeout    (sel_timeout),
    .pull_valid     (pull_valid),
    .busy           (busy),
    .step           (step_num),
    .isr_set        (isr_set),
    .fifo_pop       (seq_pop),
    .fifo_fill      (seq_fill),
    .sel_out        (sel_out),
    .push_valid     (push_valid),
    .pull_req       (pull_req),
    .ack_out        (ack_out)
  );

  scsi_seq_irq #(.W(ISR_W)) i_irq (
    .clk      (clk),
    .rst      (rst),
    .set_bits (isr_set),
    .clr      (isr_rd),
    .isr      (int_status),
    .irq      (irq)
  );

  assign fifo_rdata = f_rdata;
  assign push_data  = f_rdata;
  assign fifo_level = f_level;

  assert_ack_sets_sr_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_out) |-> int_status[ISR_SR]) else $error("ack without service request");

  assert_timeout_disc_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_out && sel_timeout) |=> (!sel_out && int_status[ISR_DIS] && irq))
    else $error("timeout did not report disconnect");

endmodule

// File: tb/test_scsi_init_seq.sv
module test_scsi_init_seq;

  localparam int DEPTH = 16;
  localparam int CW    = 6;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_we = 0, fifo_we = 0, fifo_re = 0, xfer_we = 0, isr_rd = 0;
  logic [7:0]    cmd_data = 0, fifo_wdata = 0;
  logic [CW-1:0] xfer_wdata = 0;
  logic          initiator_mode = 1, phase_chg = 0, sel_done = 0, sel_timeout = 0;
  logic [2:0]    bus_phase = 3'd4;
  logic          pull_valid;
  logic [7:0]    pull_data;
  logic          busy, irq, sel_out, push_valid, pull_req, ack_out;
  logic [7:0]    fifo_rdata, push_data;
  logic [LW-1:0] fifo_level;
  logic [3:0]    int_status;
  logic [2:0]    step_num;

  int n_tests = 0, n_fail = 0;
  int n_push = 0, n_pulled = 0;
  logic [7:0] pushed [64];

  always #10 clk = ~clk;

  scsi_init_seq #(.FIFO_DEPTH(DEPTH), .CNT_W(CW)) i_scsi_init_seq (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data), .busy(busy),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .fifo_re(fifo_re),
    .fifo_rdata(fifo_rdata), .fifo_level(fifo_level), .xfer_we(xfer_we),
    .xfer_wdata(xfer_wdata), .isr_rd(isr_rd), .int_status(int_status),
    .step_num(step_num), .irq(irq), .initiator_mode(initiator_mode),
    .bus_phase(bus_phase), .phase_chg(phase_chg), .sel_out(sel_out),
    .sel_done(sel_done), .sel_timeout(sel_timeout), .push_valid(push_valid),
    .push_data(push_data), .pull_req(pull_req), .pull_valid(pull_valid),
    .pull_data(pull_data), .ack_out(ack_out)
  );

  // bus model: collect pushed bytes, answer pull requests
  initial begin
    pull_valid = 1'b0;
    pull_data  = 8'h00;
    forever begin
      @(negedge clk);
      if (push_valid) begin
        if (n_push < 64) pushed[n_push] = push_data;
        n_push++;
      end
      if (pull_req && !rst) begin
        pull_valid = 1'b1;
        pull_data  = 8'hA0 + 8'(n_pulled);
        n_pulled++;
      end else begin
        pull_valid = 1'b0;
      end
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
    $finish;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] b);
    fifo_we = 1; fifo_wdata = b; cyc(1); fifo_we = 0;
  endtask

  task automatic host_rd(output logic [7:0] b);
    fifo_re = 1; cyc(1); fifo_re = 0; b = fifo_rdata;
  endtask

  task automatic issue(input logic [7:0] c);
    cmd_we = 1; cmd_data = c; cyc(1); cmd_we = 0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 200) begin cyc(1); k++; end
    cyc(2);
  endtask

  task automatic clr_isr();
    isr_rd = 1; cyc(1); isr_rd = 0;
  endtask

  task automatic flush();
    logic [7:0] b;
    int n = int'(fifo_level);
    for (int i = 0; i < n; i++) host_rd(b);
  endtask

  task automatic pulse_phase(input logic [2:0] p);
    bus_phase = p; phase_chg = 1; cyc(1); phase_chg = 0;
  endtask

  task automatic load_cnt(input int c);
    xfer_we = 1; xfer_wdata = CW'(c); cyc(1); xfer_we = 0;
  endtask

  initial begin
    logic [7:0] b;
    int exp, lim;

    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    chk(!busy && !irq && int_status == 0, "R1 idle/status", int'(int_status), 0);
    chk(step_num == 0 && fifo_level == 0, "R1 step/level", int'(fifo_level), 0);
    chk(!sel_out && !ack_out && !pull_req, "R1 bus lines", int'(sel_out), 0);

    // R3 FIFO fill sweep incl. overfill
    for (int k = 0; k <= 18; k++) begin
      for (int i = 0; i < k; i++) host_wr(8'(k * 7 + i));
      lim = (k < DEPTH) ? k : DEPTH;
      chk(int'(fifo_level) == lim, "R3 level", int'(fifo_level), lim);
      for (int i = 0; i < lim; i++) begin
        host_rd(b);
        chk(b == 8'(k * 7 + i), "R3 order", int'(b), (k * 7 + i) % 256);
      end
    end

    // R13 enable selection is a no-op; R2 DMA bit does not change decode
    issue(8'h44); cyc(1);
    chk(int_status == 0 && !busy && !irq, "R13 no effect", int'(int_status), 0);
    issue(8'hC4); cyc(1);
    chk(int_status == 0 && !busy, "R2 dma flag decode", int'(int_status), 0);

    // R2 unknown code rejected; R12 read clears
    issue(8'h05);
    chk(int_status == 4'h8 && irq, "R2 reject", int'(int_status), 8);
    clr_isr();
    chk(int_status == 0 && !irq, "R12 clear", int'(int_status), 0);

    // R9 transfer while not initiator, and in bus free phase
    host_wr(8'h11); host_wr(8'h22);
    initiator_mode = 0; bus_phase = 3'd2; n_push = 0;
    issue(8'h10); cyc(2);
    chk(int_status == 4'h8 && irq && n_push == 0 && fifo_level == 2, "R9 not initiator",
        int'(int_status), 8);
    clr_isr();
    initiator_mode = 1; bus_phase = 3'd4;
    issue(8'h10); cyc(2);
    chk(int_status == 4'h8 && n_push == 0 && fifo_level == 2, "R9 bus free", int'(int_status), 8);
    clr_isr(); flush();

    // R10 output transfer sweep over phases and byte counts
    for (int p = 0; p < 3; p++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        bus_phase = (p == 0) ? 3'd0 : (p == 1) ? 3'd2 : 3'd6;
        for (int i = 0; i < n; i++) host_wr(8'(p * 40 + n + i));
        n_push = 0;
        issue(8'h10);
        wait_idle();
        chk(n_push == n, "R10 push count", n_push, n);
        for (int i = 0; i < n; i++)
          chk(pushed[i] == 8'(p * 40 + n + i), "R10 push order", int'(pushed[i]),
              (p * 40 + n + i) % 256);
        chk(fifo_level == 0 && int_status == 4'h2, "R10 empty+SR", int'(int_status), 2);
        clr_isr();
      end
    end

    // R11 DMA input sweep: occupancy x transfer count
    for (int o = 0; o <= DEPTH; o++) begin
      for (int c = 0; c <= 20; c++) begin
        for (int i = 0; i < o; i++) host_wr(8'(i));
        load_cnt(c);
        bus_phase = 3'd1; n_pulled = 0;
        issue(8'h90);
        wait_idle();
        exp = (c < DEPTH - o) ? c : DEPTH - o;
        chk(n_pulled == exp, "R11 dma count", n_pulled, exp);
        chk(int'(fifo_level) == o + exp && int_status == 4'h2, "R11 level+SR",
            int'(fifo_level), o + exp);
        clr_isr(); flush();
      end
    end

    // R11 single-byte cases: no DMA, or DMA outside data in
    for (int o = 0; o <= DEPTH; o += 8) begin
      for (int m = 0; m < 3; m++) begin
        for (int i = 0; i < o; i++) host_wr(8'(i));
        load_cnt(10);
        bus_phase = (m == 0) ? 3'd1 : (m == 1) ? 3'd7 : 3'd3;
        n_pulled = 0;
        issue((m == 0) ? 8'h10 : 8'h90);
        wait_idle();
        lim = (o < DEPTH) ? o + 1 : DEPTH;
        chk(n_pulled == 1, "R11 one byte", n_pulled, 1);
        chk(int'(fifo_level) == lim && int_status == 4'h2, "R11 one byte level",
            int'(fifo_level), lim);
        clr_isr(); flush();
      end
    end

    // R4 select without attention, R7 bus free ignored, R2/R3 busy ignores host
    for (int i = 0; i < 6; i++) host_wr(8'h30 + 8'(i));
    bus_phase = 3'd4;
    issue(8'h41); cyc(1);
    chk(sel_out && busy, "R4 sel asserted", int'(sel_out), 1);
    issue(8'h05); cyc(1);
    chk(int_status == 0, "R2 busy ignores cmd", int'(int_status), 0);
    host_wr(8'hEE);
    chk(fifo_level == 6, "R3 busy ignores host", int'(fifo_level), 6);
    sel_done = 1; cyc(1); sel_done = 0;
    chk(!sel_out, "R4 sel released", int'(sel_out), 0);
    n_push = 0;
    pulse_phase(3'd4); cyc(3);
    chk(n_push == 0 && step_num == 0 && busy, "R7 bus free ignored", n_push, 0);
    pulse_phase(3'd2); cyc(10);
    chk(n_push == 6 && step_num == 3 && int_status == 0 && busy, "R4 cmd bytes", n_push, 6);
    for (int i = 0; i < 6; i++)
      chk(pushed[i] == 8'h30 + 8'(i), "R4 cmd order", int'(pushed[i]), 48 + i);
    pulse_phase(3'd3); cyc(1);
    chk(step_num == 4 && int_status == 4'h3 && irq && !busy, "R4 complete",
        int'(int_status), 3);

    // R12 step cleared on start; R6 selection timeout
    clr_isr();
    issue(8'h41); cyc(1);
    chk(step_num == 0 && sel_out, "R12 step cleared at start", int'(step_num), 0);
    sel_timeout = 1; cyc(1); sel_timeout = 0;
    chk(!sel_out && !busy && step_num == 0 && int_status == 4'h4 && irq, "R6 timeout",
        int'(int_status), 4);
    clr_isr(); flush();

    // R5 select with attention
    for (int i = 0; i < 4; i++) host_wr(8'h50 + 8'(i));
    issue(8'h42); cyc(1);
    sel_done = 1; cyc(1); sel_done = 0;
    n_push = 0;
    pulse_phase(3'd6); cyc(4);
    chk(n_push == 1 && pushed[0] == 8'h50 && step_num == 2 && fifo_level == 3,
        "R5 message byte", n_push, 1);
    pulse_phase(3'd2); cyc(6);
    chk(n_push == 4 && step_num == 3, "R5 cmd bytes", n_push, 4);
    for (int i = 1; i < 4; i++)
      chk(pushed[i] == 8'h50 + 8'(i), "R5 cmd order", int'(pushed[i]), 80 + i);
    pulse_phase(3'd3); cyc(1);
    chk(step_num == 4 && int_status == 4'h3 && !busy, "R5 complete", int'(int_status), 3);
    clr_isr();

    // R8 complete steps outside and inside STATUS, then message accepted
    bus_phase = 3'd1; n_pulled = 0;
    issue(8'h11); cyc(1);
    chk(int_status == 4'h8 && n_pulled == 0 && !busy, "R8 reject", int'(int_status), 8);
    clr_isr();
    bus_phase = 3'd3; n_pulled = 0;
    issue(8'h11);
    wait_idle();
    chk(n_pulled == 2 && fifo_level == 2 && ack_out && int_status == 4'h2, "R8 status+msg",
        n_pulled, 2);
    host_rd(b);
    chk(b == 8'hA0, "R8 status byte", int'(b), 160);
    host_rd(b);
    chk(b == 8'hA1, "R8 message byte", int'(b), 161);
    clr_isr();
    issue(8'h12); cyc(1);
    chk(!ack_out && int_status == 4'h2, "R8 msg accepted", int'(ack_out), 0);
    clr_isr();

    // R7 phase change while idle
    host_wr(8'h01); host_wr(8'h02);
    n_push = 0;
    pulse_phase(3'd2); cyc(3);
    chk(n_push == 0 && fifo_level == 2 && int_status == 0 && step_num == 0 && !busy,
        "R7 idle phase change", n_push, 0);

    report();
    $finish;
  end

endmodule